// File: doc/BRIEF.md
# Link-Port Protocol Controller

This block is the sequencing state machine for a byte-wide double-data-rate link port. It decides at every local clock whether the link is idle, running a connectivity check before a transmission, transmitting, resting after a capped burst, or receiving. From that decision it drives the enables of the transmit and receive byte datapaths, the direction of the shared link, and the check-byte enables for both directions. It never touches the data bytes.

A transmit burst may start only after the far end acknowledges. Each burst can be capped at a fixed number of transfers, or left uncapped. The verification-enable setting and the burst-size setting are captured once when the link leaves idle, and the same verification setting applies to both directions. Receive and transmit inactivity time-outs raise sticky flags. These flags stay high until the user pulses the clear input, and the sequencer never reads them. An unused clear input must be tied low.

Top module: `lp_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every output is low and the controller is idle.
- R2: When the controller is idle and both a receive request and a transmit request are present, receive wins. `dir_o` is 1 while checking or transmitting and 0 while receiving or idle. `rx_en_o` and `dir_o` are never high together.
- R3: A transmit burst starts (`tx_en_o` rises) only after `link_ack_i` is seen during the check. If there is no acknowledge for CHECK_CYCLES (16) clocks, `ack_bad_o` goes high and the controller returns to idle. The next successful check clears `ack_bad_o`.
- R4: With `burst_unlim_i` = 0, `tx_en_o` drops at the 64th counted transfer even if more data is pending. `dir_o` then stays 0 for GAP_CYCLES (2) clocks, which is one link clock, before the next check begins.
- R5: With `burst_unlim_i` = 1, a burst continues past 64 transfers for as long as data is pending.
- R6: `verify_en_i` and `burst_unlim_i` are sampled when the link leaves idle. The sampled verification value appears on `vfy_tx_o` while checking or transmitting and on `vfy_rx_o` while receiving. A change during a burst has no effect.
- R7: During a transmit with no `xfer_tick_i` for TIMEOUT_CYCLES (1024) clocks, `tx_timeout_o` goes high and the transmit ends.
- R8: During a receive with no `rx_activity_i` for TIMEOUT_CYCLES clocks, `rx_timeout_o` goes high. Each activity pulse restarts the count.
- R9: The time-out flags stay high until `to_clear_i` is high for one clock, which clears them. A set flag does not stop a new burst from starting.
- R10: A transmit burst ends at a transfer where `tx_pending_i` is low. A receive ends when `rx_request_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock (twice the link clock) |
| rst_n | input | 1 | Synchronous active-low reset |
| verify_en_i | input | 1 | Check-byte enable for both directions |
| burst_unlim_i | input | 1 | 0: bursts capped at 64 transfers; 1: unlimited |
| to_clear_i | input | 1 | One-clock pulse clearing both time-out flags |
| tx_pending_i | input | 1 | Transmit datapath holds data to send |
| rx_request_i | input | 1 | Far end is driving an incoming transfer |
| link_ack_i | input | 1 | Far end acknowledge used by the connectivity check |
| xfer_tick_i | input | 1 | One transmit transfer completed this clock |
| rx_activity_i | input | 1 | Incoming transfer observed this clock |
| tx_en_o | output | 1 | Transmit datapath enable |
| rx_en_o | output | 1 | Receive datapath enable |
| dir_o | output | 1 | Link direction, 1 = driving out |
| vfy_tx_o | output | 1 | Check-byte insertion enable for transmit |
| vfy_rx_o | output | 1 | Check-byte checking enable for receive |
| ack_bad_o | output | 1 | Connectivity check failed |
| rx_timeout_o | output | 1 | Sticky receive time-out |
| tx_timeout_o | output | 1 | Sticky transmit time-out |

## Verification
The bench counts transfers to the exact cycle of the 64th one. A cap that is off by one would leave `tx_en_o` high one sample too long or drop it one sample early. It also watches the two rest clocks, which a design would skip if it went straight back to checking. Time-outs are sampled well before and just after the 1024-clock window. Activity pulses are spaced inside that window, so a receive timer that failed to restart would raise its flag too early. The bench also flips the verification input in the middle of a burst, sends a receive request in the same clock as a transmit request, and shows that a set flag survives until the clear pulse without blocking the next burst.

// File: rtl/lp_ctrl_pkg.sv
// Package: shared state encoding for the link-port controller.
package lp_ctrl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_TX    = 3'd2,
        ST_GAP   = 3'd3,
        ST_RX    = 3'd4
    } lp_state_e;
endpackage

// File: rtl/lp_watch.sv
// Inactivity watch: counts clocks while run is high and kick is low.
// Raises fired in the clock that completes LIMIT quiet clocks.
// Assumes LIMIT >= 1. The count restarts whenever run drops or kick pulses.
module lp_watch #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic kick,
    output logic fired
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Count quiet clocks; restart on kick or when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || kick || fired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign fired = run && !kick && (cnt == LAST);
endmodule

// File: rtl/lp_burst_count.sv
// Burst transfer counter: counts transfers inside one transmit burst.
// Flags the transfer that reaches BURST_MAX when the cap is active.
// Assumes clear is held high whenever no burst is running.
module lp_burst_count #(
    parameter int BURST_MAX = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic unlim,
    output logic limit_hit
);
    localparam int W = (BURST_MAX > 1) ? $clog2(BURST_MAX) : 1;
    localparam logic [W-1:0] LAST = W'(BURST_MAX - 1);

    logic [W-1:0] cnt;

    // Advance once per transfer; wraps harmlessly when uncapped.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign limit_hit = tick && !unlim && (cnt == LAST);
endmodule

// File: rtl/lp_sticky_flags.sv
// Sticky flag bank: each bit sets on its event and holds until a clear pulse.
// A set and a clear in the same clock leave the bit set.
module lp_sticky_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold one flag: set wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else if (set[i]) begin
                q[i] <= 1'b1;
            end else if (clr) begin
                q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lp_ctrl.sv
// Link-port protocol controller top.
// Sequences the link through idle, check, transmit, gap and receive.
// Owns the burst cap, the connectivity check and the sticky time-outs.
// Assumes all inputs are synchronous to clk. The time-out flags are not fed
// back into the sequencing.
module lp_ctrl
    import lp_ctrl_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1024,
    parameter int CHECK_CYCLES   = 16,
    parameter int BURST_MAX      = 64,
    parameter int GAP_CYCLES     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic verify_en_i,
    input  logic burst_unlim_i,
    input  logic to_clear_i,
    input  logic tx_pending_i,
    input  logic rx_request_i,
    input  logic link_ack_i,
    input  logic xfer_tick_i,
    input  logic rx_activity_i,
    output logic tx_en_o,
    output logic rx_en_o,
    output logic dir_o,
    output logic vfy_tx_o,
    output logic vfy_rx_o,
    output logic ack_bad_o,
    output logic rx_timeout_o,
    output logic tx_timeout_o
);
    localparam int NFLAG = 2;

    lp_state_e state, state_nx;
    logic cfg_vfy, cfg_unlim;
    logic chk_fire, tx_fire, rx_fire, gap_fire, limit_hit;
    logic [NFLAG-1:0] flag_set, flag_q;

    lp_watch #(.LIMIT(CHECK_CYCLES)) u_check_watch (
        .clk(clk), .rst_n(rst_n), .run(state == ST_CHECK),
        .kick(link_ack_i), .fired(chk_fire));

    lp_watch #(.LIMIT(TIMEOUT_CYCLES)) u_tx_watch (
        .clk(clk), .rst_n(rst_n), .run(state == ST_TX),
        .kick(xfer_tick_i), .fired(tx_fire));

    lp_watch #(.LIMIT(TIMEOUT_CYCLES)) u_rx_watch (
        .clk(clk), .rst_n(rst_n), .run(state == ST_RX),
        .kick(rx_activity_i), .fired(rx_fire));

    lp_watch #(.LIMIT(GAP_CYCLES)) u_gap_watch (
        .clk(clk), .rst_n(rst_n), .run(state == ST_GAP),
        .kick(1'b0), .fired(gap_fire));

    lp_burst_count #(.BURST_MAX(BURST_MAX)) u_burst (
        .clk(clk), .rst_n(rst_n), .clear(state != ST_TX),
        .tick(xfer_tick_i && (state == ST_TX)), .unlim(cfg_unlim),
        .limit_hit(limit_hit));

    assign flag_set = {tx_fire, rx_fire};

    lp_sticky_flags #(.N(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(to_clear_i),
        .q(flag_q));

    // Choose the next link state from the current state and datapath status.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (rx_request_i)      state_nx = ST_RX;
                else if (tx_pending_i) state_nx = ST_CHECK;
            end
            ST_CHECK: begin
                if (link_ack_i)    state_nx = ST_TX;
                else if (chk_fire) state_nx = ST_IDLE;
            end
            ST_TX: begin
                if (tx_fire)        state_nx = ST_IDLE;
                else if (limit_hit) state_nx = ST_GAP;
                else if (xfer_tick_i && !tx_pending_i) state_nx = ST_IDLE;
            end
            ST_GAP: begin
                if (gap_fire) state_nx = ST_IDLE;
            end
            ST_RX: begin
                if (rx_fire || !rx_request_i) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Register the state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Capture the burst configuration as the link leaves idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_vfy   <= 1'b0;
            cfg_unlim <= 1'b0;
        end else if (state == ST_IDLE && (rx_request_i || tx_pending_i)) begin
            cfg_vfy   <= verify_en_i;
            cfg_unlim <= burst_unlim_i;
        end
    end

    // Record the outcome of each connectivity check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_bad_o <= 1'b0;
        end else if (state == ST_CHECK) begin
            if (link_ack_i)    ack_bad_o <= 1'b0;
            else if (chk_fire) ack_bad_o <= 1'b1;
        end
    end

    assign tx_en_o      = (state == ST_TX);
    assign rx_en_o      = (state == ST_RX);
    assign dir_o        = (state == ST_TX) || (state == ST_CHECK);
    assign vfy_tx_o     = cfg_vfy && dir_o;
    assign vfy_rx_o     = cfg_vfy && rx_en_o;
    assign rx_timeout_o = flag_q[0];
    assign tx_timeout_o = flag_q[1];
endmodule

// File: rtl/lp_ctrl_chk.sv
// Property checker for lp_ctrl, attached with bind. It observes ports only.
module lp_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic verify_en_i,
    input logic to_clear_i,
    input logic link_ack_i,
    input logic tx_en_o,
    input logic rx_en_o,
    input logic dir_o,
    input logic vfy_tx_o,
    input logic rx_timeout_o,
    input logic tx_timeout_o
);
    assert_dir_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_en_o && dir_o));

    assert_tx_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_o |-> dir_o);

    assert_ack_before_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en_o) |-> $past(link_ack_i));

    assert_rest_after_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en_o) |=> !tx_en_o);

    assert_vfy_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_o && $past(tx_en_o)) |-> $stable(vfy_tx_o));

    assert_rx_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_timeout_o && !to_clear_i) |=> rx_timeout_o);

    assert_tx_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_timeout_o && !to_clear_i) |=> tx_timeout_o);
endmodule

bind lp_ctrl lp_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .verify_en_i(verify_en_i),
    .to_clear_i(to_clear_i), .link_ack_i(link_ack_i),
    .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .dir_o(dir_o),
    .vfy_tx_o(vfy_tx_o), .rx_timeout_o(rx_timeout_o),
    .tx_timeout_o(tx_timeout_o));

// File: tb/tb_lp_ctrl.sv
// Directed bench for lp_ctrl: one task per scenario, each checking its results.
module tb_lp_ctrl;
    logic clk = 1'b0;
    logic rst_n, verify_en_i, burst_unlim_i, to_clear_i, tx_pending_i;
    logic rx_request_i, link_ack_i, xfer_tick_i, rx_activity_i;
    logic tx_en_o, rx_en_o, dir_o, vfy_tx_o, vfy_rx_o, ack_bad_o;
    logic rx_timeout_o, tx_timeout_o;
    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    lp_ctrl dut (
        .clk(clk), .rst_n(rst_n), .verify_en_i(verify_en_i),
        .burst_unlim_i(burst_unlim_i), .to_clear_i(to_clear_i),
        .tx_pending_i(tx_pending_i), .rx_request_i(rx_request_i),
        .link_ack_i(link_ack_i), .xfer_tick_i(xfer_tick_i),
        .rx_activity_i(rx_activity_i), .tx_en_o(tx_en_o), .rx_en_o(rx_en_o),
        .dir_o(dir_o), .vfy_tx_o(vfy_tx_o), .vfy_rx_o(vfy_rx_o),
        .ack_bad_o(ack_bad_o), .rx_timeout_o(rx_timeout_o),
        .tx_timeout_o(tx_timeout_o));

    task automatic chk(input string req, input string what,
                       input logic actual, input logic expected);
        n_checks++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, actual, expected);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; verify_en_i = 1'b0; burst_unlim_i = 1'b0; to_clear_i = 1'b0;
        tx_pending_i = 1'b0; rx_request_i = 1'b0; link_ack_i = 1'b0;
        xfer_tick_i = 1'b0; rx_activity_i = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1", "tx_en", tx_en_o, 1'b0);
        chk("R1", "rx_en", rx_en_o, 1'b0);
        chk("R1", "dir", dir_o, 1'b0);
        chk("R1", "ack_bad", ack_bad_o, 1'b0);
        chk("R1", "flags", rx_timeout_o | tx_timeout_o | vfy_tx_o | vfy_rx_o, 1'b0);
    endtask

    task automatic t_check_fail();
        tx_pending_i = 1'b1; link_ack_i = 1'b0;
        step(1);
        chk("R2", "dir in check", dir_o, 1'b1);
        chk("R3", "no tx before ack", tx_en_o, 1'b0);
        step(14);
        chk("R3", "ack_bad before window", ack_bad_o, 1'b0);
        step(2);
        chk("R3", "ack_bad after window", ack_bad_o, 1'b1);
        chk("R3", "idle after fail", dir_o, 1'b0);
        tx_pending_i = 1'b0;
        step(3);
        chk("R3", "ack_bad holds", ack_bad_o, 1'b1);
    endtask

    task automatic t_burst_cap();
        burst_unlim_i = 1'b0; verify_en_i = 1'b1;
        tx_pending_i = 1'b1; link_ack_i = 1'b1;
        step(1);
        chk("R6", "vfy_tx in check", vfy_tx_o, 1'b1);
        step(1);
        chk("R3", "tx after ack", tx_en_o, 1'b1);
        chk("R3", "ack_bad cleared", ack_bad_o, 1'b0);
        xfer_tick_i = 1'b1; verify_en_i = 1'b0;
        step(63);
        chk("R4", "tx through 63rd", tx_en_o, 1'b1);
        chk("R6", "vfy_tx unchanged mid-burst", vfy_tx_o, 1'b1);
        chk("R6", "vfy_rx low in tx", vfy_rx_o, 1'b0);
        step(1);
        chk("R4", "tx off at 64th", tx_en_o, 1'b0);
        chk("R4", "dir rest 1", dir_o, 1'b0);
        xfer_tick_i = 1'b0;
        step(1);
        chk("R4", "dir rest 2", dir_o, 1'b0);
        step(1);
        chk("R4", "idle after rest", dir_o, 1'b0);
        step(1);
        chk("R4", "check resumes", dir_o, 1'b1);
        chk("R6", "new vfy sampled", vfy_tx_o, 1'b0);
        step(1);
        chk("R4", "next burst", tx_en_o, 1'b1);
        tx_pending_i = 1'b0; xfer_tick_i = 1'b1;
        step(1);
        chk("R10", "ends when drained", tx_en_o, 1'b0);
        xfer_tick_i = 1'b0;
        step(1);
    endtask

    task automatic t_unlimited();
        burst_unlim_i = 1'b1; tx_pending_i = 1'b1; link_ack_i = 1'b1;
        step(2);
        chk("R5", "tx started", tx_en_o, 1'b1);
        xfer_tick_i = 1'b1; burst_unlim_i = 1'b0;
        step(100);
        chk("R5", "past 64 transfers", tx_en_o, 1'b1);
        tx_pending_i = 1'b0;
        step(1);
        chk("R10", "unlimited ends when drained", tx_en_o, 1'b0);
        xfer_tick_i = 1'b0;
        step(2);
    endtask

    task automatic t_tx_timeout();
        burst_unlim_i = 1'b0; tx_pending_i = 1'b1; link_ack_i = 1'b1;
        step(2);
        step(1000);
        chk("R7", "no early tx timeout", tx_timeout_o, 1'b0);
        chk("R7", "still transmitting", tx_en_o, 1'b1);
        step(30);
        chk("R7", "tx timeout set", tx_timeout_o, 1'b1);
        tx_pending_i = 1'b0;
        step(5);
        chk("R9", "tx flag sticky", tx_timeout_o, 1'b1);
        tx_pending_i = 1'b1;
        step(2);
        chk("R9", "burst starts with flag set", tx_en_o, 1'b1);
        tx_pending_i = 1'b0; xfer_tick_i = 1'b1;
        step(1);
        xfer_tick_i = 1'b0; to_clear_i = 1'b1;
        step(1);
        to_clear_i = 1'b0;
        step(1);
        chk("R9", "tx flag cleared", tx_timeout_o, 1'b0);
    endtask

    task automatic t_rx();
        verify_en_i = 1'b1; rx_request_i = 1'b1; tx_pending_i = 1'b1; link_ack_i = 1'b0;
        step(1);
        chk("R2", "rx wins", rx_en_o, 1'b1);
        chk("R2", "dir low in rx", dir_o, 1'b0);
        chk("R6", "vfy_rx in rx", vfy_rx_o, 1'b1);
        tx_pending_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step(500);
            rx_activity_i = 1'b1;
            step(1);
            rx_activity_i = 1'b0;
        end
        chk("R8", "activity restarts timer", rx_timeout_o, 1'b0);
        step(1000);
        chk("R8", "no early rx timeout", rx_timeout_o, 1'b0);
        step(30);
        chk("R8", "rx timeout set", rx_timeout_o, 1'b1);
        rx_request_i = 1'b0;
        step(5);
        chk("R10", "rx ends on request drop", rx_en_o, 1'b0);
        chk("R9", "rx flag sticky", rx_timeout_o, 1'b1);
        to_clear_i = 1'b1;
        step(1);
        to_clear_i = 1'b0;
        step(1);
        chk("R9", "rx flag cleared", rx_timeout_o, 1'b0);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        t_reset();
        t_check_fail();
        t_burst_cap();
        t_unlimited();
        t_tx_timeout();
        t_rx();
        finish_run();
    end
endmodule